// File: doc/BRIEF.md
# Pending-Table Highest-Priority Scanner

This block finds the most urgent pending message-signalled interrupt for one processor. The pending state of every such interrupt lives as one bit in a bitmap in external memory. Each interrupt also has one configuration byte in a second table, which holds an enable bit and a priority field. When a start strobe arrives, the block reads the bitmap one byte at a time through a simple byte-read master port. For each set bit, it fetches that interrupt's configuration byte. It keeps a running best and pulses a done flag when the walk ends.

Message interrupt IDs begin at 8192. The bitmap bytes that cover lower IDs are never read. The size of the bitmap comes from an ID-width field, which is clipped to an implementation maximum. The priority seen by the comparison depends on a security-disable input. Ties go to the lower ID. A winner is always reported as belonging to the non-secure group 1.

Top module: `msg_pend_scanner`

## Requirements
- R1: A start pulse does nothing unless scan_en_i is 1, cfg_base_i is nonzero and pend_base_i is nonzero. A start that fails this test issues no memory request, raises no done_o, and leaves best_id_o, best_prio_o and best_grp_o unchanged.
- R2: An accepted start sets best_prio_o to 0xFF. If no enabled pending interrupt is found, best_prio_o stays 0xFF, and best_id_o and best_grp_o keep their previous values (after reset these are 0xFF, 0 and 0).
- R3: The effective width is min(id_bits_i, IMPL_ID_BITS), where IMPL_ID_BITS defaults to 13. The bitmap covers 2^(width+1) bits. Bytes are scanned from index 1024 (8192/8) up to, but not including, index 2^(width+1)/8. If that range is empty, done_o pulses and no memory read is made.
- R4: Each pending byte is read from pend_base_i + byte index, in ascending byte order. Within a byte, set bits are visited from bit 0 to bit 7, and the interrupt ID is byte index × 8 + bit.
- R5: For each pending ID, the configuration byte is read from cfg_base_i + (ID − 8192). Bit 0 of that byte is the enable. An entry with bit 0 clear is skipped.
- R6: With sec_dis_i = 1, the priority is cfg & 0xFC. With sec_dis_i = 0, it is ((cfg & 0xFC) >> 1) | 0x80.
- R7: A candidate replaces the best when its priority is strictly lower. It also replaces the best when its priority is equal and its ID is less than or equal to the best ID. The result is therefore the lowest ID among the lowest priority value.
- R8: A winning interrupt sets best_grp_o to 2, the code for non-secure group 1 (0 = group 0, 1 = secure group 1).
- R9: At most one read is outstanding. A request is accepted when req_valid_o and req_ready_i are both high, and it then waits for rsp_valid_i. While req_valid_o waits for ready, it stays high and req_addr_o does not change.
- R10: done_o is high for exactly one cycle per accepted scan. A start pulse during a scan is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a scan |
| scan_en_i | input | 1 | Message interrupts enabled |
| sec_dis_i | input | 1 | Security disabled; selects the priority remap |
| cfg_base_i | input | ADDR_W | Base address of the configuration table |
| pend_base_i | input | ADDR_W | Base address of the pending bitmap |
| id_bits_i | input | IDF_W | ID-width field |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | ADDR_W | Byte address of the read |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 8 | Read data byte |
| done_o | output | 1 | Scan complete, one-cycle pulse |
| best_id_o | output | IMPL_ID_BITS+1 | ID of the best pending interrupt |
| best_prio_o | output | 8 | Its priority; 0xFF when there is none |
| best_grp_o | output | 2 | Group code of the winner |

## Verification
Two events can land on the same cycle. A second start pulse can arrive while a walk is in progress, and a start can be accepted in the very cycle that the walk ends. To provoke the first case, the bench pulses start again partway through a long scan, then checks that exactly one done pulse appears and that the result matches a single clean walk. To provoke the second case, an ID-width setting with an empty range makes the block finish in the cycle right after the start. The bench checks that done is raised once, that no read occurs and that the previous ID is kept. Random ready and latency on the memory port also place responses next to new request cycles. A protocol monitor checks that no request is made while one is outstanding.

// File: rtl/msg_scan_pkg.sv
package msg_scan_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_PREQ, S_PWAIT, S_PICK, S_CREQ, S_CWAIT, S_FIN
  } scan_state_e;

  typedef enum logic [1:0] {
    GRP_G0  = 2'd0,
    GRP_S1  = 2'd1,
    GRP_NS1 = 2'd2
  } grp_e;

  localparam logic [7:0] PRIO_FIELD = 8'hFC;
  localparam logic [7:0] PRIO_IDLE  = 8'hFF;

  function automatic logic [7:0] remap_prio(input logic [7:0] cfg, input logic sec_dis);
    logic [7:0] f;
    f = cfg & PRIO_FIELD;
    return sec_dis ? f : ((f >> 1) | 8'h80);
  endfunction

endpackage

// File: rtl/msg_scan_bitpick.sv
module msg_scan_bitpick #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] sel [W+1];
  logic          hit [W+1];

  assign sel[W] = '0;
  assign hit[W] = 1'b0;

  // lowest set bit wins: chain from MSB down
  for (genvar g = W - 1; g >= 0; g--) begin : g_chain
    assign hit[g] = vec_i[g] | hit[g+1];
    assign sel[g] = vec_i[g] ? IW'(g) : sel[g+1];
  end

  assign any_o = hit[0];
  assign idx_o = sel[0];
endmodule

// File: rtl/msg_scan_prio.sv
module msg_scan_prio
  import msg_scan_pkg::*;
#(
  parameter int ID_W = 14
) (
  input  logic [7:0]      cfg_i,
  input  logic            sec_dis_i,
  input  logic [ID_W-1:0] cand_id_i,
  input  logic [7:0]      best_prio_i,
  input  logic [ID_W-1:0] best_id_i,
  output logic            take_o,
  output logic [7:0]      prio_o
);
  logic better, tie_win;

  assign prio_o  = remap_prio(cfg_i, sec_dis_i);
  assign better  = prio_o < best_prio_i;
  assign tie_win = (prio_o == best_prio_i) && (cand_id_i <= best_id_i);
  assign take_o  = cfg_i[0] && (better || tie_win);
endmodule

// File: rtl/msg_scan_span.sv
module msg_scan_span #(
  parameter int IMPL_ID_BITS = 13,
  parameter int IDF_W        = 5,
  localparam int IDX_W       = IMPL_ID_BITS - 1
) (
  input  logic [IDF_W-1:0] id_bits_i,
  output logic [IDX_W-1:0] end_idx_o
);
  localparam int SPAN_W = IMPL_ID_BITS + 2;
  logic [IDF_W-1:0]  eff;
  logic [SPAN_W-1:0] span_bits;

  assign eff       = (id_bits_i > IDF_W'(IMPL_ID_BITS)) ? IDF_W'(IMPL_ID_BITS) : id_bits_i;
  assign span_bits = SPAN_W'(1) << (eff + IDF_W'(1));
  assign end_idx_o = span_bits[SPAN_W-1:3];
endmodule

// File: rtl/msg_pend_scanner.sv
module msg_pend_scanner
  import msg_scan_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int IMPL_ID_BITS = 13,
  parameter int IDF_W        = 5,
  parameter int FIRST_ID     = 8192,
  localparam int ID_W        = IMPL_ID_BITS + 1,
  localparam int IDX_W       = IMPL_ID_BITS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              scan_en_i,
  input  logic              sec_dis_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] pend_base_i,
  input  logic [IDF_W-1:0]  id_bits_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [7:0]        rsp_data_i,
  output logic              done_o,
  output logic [ID_W-1:0]   best_id_o,
  output logic [7:0]        best_prio_o,
  output logic [1:0]        best_grp_o
);
  localparam logic [IDX_W-1:0] START_IDX = IDX_W'(FIRST_ID / 8);

  scan_state_e       state;
  logic [IDX_W-1:0]  byte_idx, end_idx, span_end, nxt_idx;
  logic [7:0]        mask;
  logic [2:0]        bit_sel, pick_idx;
  logic              pick_any;
  logic [ADDR_W-1:0] cfg_base_q, pend_base_q;
  logic              ds_q, take;
  logic [7:0]        cand_prio;
  logic [ID_W-1:0]   cand_id;
  logic              gate_ok, busy;

  assign gate_ok = scan_en_i && (cfg_base_i != '0) && (pend_base_i != '0);
  assign busy    = state != S_IDLE;
  assign cand_id = {byte_idx[IDX_W-2:0], bit_sel};
  assign nxt_idx = byte_idx + IDX_W'(1);

  msg_scan_span #(.IMPL_ID_BITS(IMPL_ID_BITS), .IDF_W(IDF_W)) u_span (
    .id_bits_i (id_bits_i),
    .end_idx_o (span_end)
  );

  msg_scan_bitpick #(.W(8)) u_pick (
    .vec_i (mask),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  msg_scan_prio #(.ID_W(ID_W)) u_prio (
    .cfg_i       (rsp_data_i),
    .sec_dis_i   (ds_q),
    .cand_id_i   (cand_id),
    .best_prio_i (best_prio_o),
    .best_id_i   (best_id_o),
    .take_o      (take),
    .prio_o      (cand_prio)
  );

  assign req_valid_o = (state == S_PREQ) || (state == S_CREQ);
  assign req_addr_o  = (state == S_CREQ)
                     ? cfg_base_q + ADDR_W'(cand_id - ID_W'(FIRST_ID))
                     : pend_base_q + ADDR_W'(byte_idx);
  assign done_o      = state == S_FIN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= S_IDLE;
      byte_idx    <= '0;
      end_idx     <= '0;
      mask        <= '0;
      bit_sel     <= '0;
      cfg_base_q  <= '0;
      pend_base_q <= '0;
      ds_q        <= 1'b0;
      best_id_o   <= '0;
      best_prio_o <= PRIO_IDLE;
      best_grp_o  <= GRP_G0;
    end else begin
      unique case (state)
        S_IDLE: if (start_i && gate_ok) begin
          cfg_base_q  <= cfg_base_i;
          pend_base_q <= pend_base_i;
          ds_q        <= sec_dis_i;
          best_prio_o <= PRIO_IDLE;
          byte_idx    <= START_IDX;
          end_idx     <= span_end;
          state       <= (span_end <= START_IDX) ? S_FIN : S_PREQ;
        end
        S_PREQ:  if (req_ready_i) state <= S_PWAIT;
        S_PWAIT: if (rsp_valid_i) begin
          mask  <= rsp_data_i;
          state <= S_PICK;
        end
        S_PICK: if (pick_any) begin
          bit_sel <= pick_idx;
          mask    <= mask & ~(8'b1 << pick_idx);
          state   <= S_CREQ;
        end else begin
          byte_idx <= nxt_idx;
          state    <= (nxt_idx == end_idx) ? S_FIN : S_PREQ;
        end
        S_CREQ:  if (req_ready_i) state <= S_CWAIT;
        S_CWAIT: if (rsp_valid_i) begin
          if (take) begin
            best_prio_o <= cand_prio;
            best_id_o   <= cand_id;
            best_grp_o  <= GRP_NS1;
          end
          state <= S_PICK;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: a refused start leaves the block idle
  a_r1_gate_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i && !scan_en_i) |=> !busy);

  // R2: the best priority reads idle when a walk begins
  a_r2_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> best_prio_o == PRIO_IDLE);

  // R7: the best priority never gets worse during a walk
  a_r7_best_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> best_prio_o <= $past(best_prio_o));

  a_r8_winner_grp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && best_prio_o != PRIO_IDLE) |-> best_grp_o == GRP_NS1);

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4: pending reads stay inside the scanned byte window
  a_r4_pend_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_PREQ) |-> (byte_idx >= START_IDX && byte_idx < end_idx));
endmodule

// File: tb/msg_pend_scanner_test.sv
module msg_pend_scanner_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PB = 32'h1000_0000;
  localparam logic [31:0] CB = 32'h2000_0000;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic        scan_en_i = 1'b1, sec_dis_i = 1'b1;
  logic [31:0] cfg_base_i = CB, pend_base_i = PB;
  logic [4:0]  id_bits_i = 5'd13;
  logic        req_valid_o, req_ready_i, rsp_valid_i;
  logic [31:0] req_addr_o;
  logic [7:0]  rsp_data_i;
  logic        done_o;
  logic [13:0] best_id_o;
  logic [7:0]  best_prio_o;
  logic [1:0]  best_grp_o;

  msg_pend_scanner uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .scan_en_i(scan_en_i),
    .sec_dis_i(sec_dis_i), .cfg_base_i(cfg_base_i), .pend_base_i(pend_base_i),
    .id_bits_i(id_bits_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .done_o(done_o), .best_id_o(best_id_o), .best_prio_o(best_prio_o),
    .best_grp_o(best_grp_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic [7:0] mem [logic [31:0]];
  int total = 0, bad = 0, reads = 0, done_cnt = 0, proto_bad = 0;
  bit finished = 0;
  int exp_id = 0, exp_prio = 8'hFF, exp_grp = 0;

  function automatic logic [7:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // reference walk computed from the requirements
  task automatic model(input int idb, input bit ds);
    int eff, nbytes, bp, bi, p, id;
    logic [7:0] pend, c;
    eff = (idb > 13) ? 13 : idb;
    nbytes = (1 << (eff + 1)) / 8;
    bp = 8'hFF; bi = exp_id;
    for (int b = 1024; b < nbytes; b++) begin
      pend = rd(PB + 32'(b));
      for (int k = 0; k < 8; k++) if (pend[k]) begin
        id = b * 8 + k;
        c = rd(CB + 32'(id - 8192));
        if (c[0]) begin
          p = ds ? int'(c & 8'hFC) : int'(((c & 8'hFC) >> 1) | 8'h80);
          if (p < bp || (p == bp && id <= bi)) begin bp = p; bi = id; exp_grp = 2; end
        end
      end
    end
    exp_prio = bp; exp_id = bi;
  endtask

  task automatic set_pend(input int id, input logic [7:0] cfg);
    logic [31:0] a;
    a = PB + 32'(id / 8);
    mem[a] = rd(a) | (8'b1 << (id % 8));
    mem[CB + 32'(id - 8192)] = cfg;
  endtask

  // memory responder with random ready and latency
  initial begin
    int lat = 0;
    bit acc = 0, pv = 0, pacc = 0;
    logic [31:0] acc_addr = '0, paddr = '0;
    logic [7:0] hold = '0;
    req_ready_i = 0; rsp_valid_i = 0; rsp_data_i = 0;
    forever begin
      @(negedge clk_i);
      if (done_o) done_cnt++;
      rsp_valid_i = 0;
      if (acc) begin lat = 1 + int'($urandom % 3); hold = rd(acc_addr); acc = 0; end
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin rsp_valid_i = 1; rsp_data_i = hold; end
      end
      if (req_valid_o && (lat > 0 || rsp_valid_i)) proto_bad++;
      if (pv && !pacc && (!req_valid_o || req_addr_o != paddr)) proto_bad++;
      req_ready_i = (lat == 0 && !rsp_valid_i) ? ($urandom % 4 != 0) : 1'b0;
      acc = req_valid_o && req_ready_i;
      acc_addr = req_addr_o;
      if (acc) reads++;
      pv = req_valid_o; pacc = acc; paddr = req_addr_o;
    end
  end

  task automatic run_scan(input int idb, input bit ds, input int restart_at);
    int cyc = 0;
    @(negedge clk_i);
    id_bits_i = 5'(idb); sec_dis_i = ds; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    while (!done_o && cyc < 30000) begin
      @(negedge clk_i);
      cyc++;
      if (cyc == restart_at) begin start_i = 1; @(negedge clk_i); start_i = 0; end
    end
    chk(done_o, "R10", "done seen", int'(done_o), 1);
  endtask

  task automatic check_result(input string req);
    chk(best_prio_o == 8'(exp_prio), req, "prio", best_prio_o, exp_prio);
    chk(best_id_o == 14'(exp_id), req, "id", best_id_o, exp_id);
    chk(best_grp_o == 2'(exp_grp), "R8", "grp", best_grp_o, exp_grp);
  endtask

  task automatic scan_and_check(input int idb, input bit ds, input string req, input int restart_at);
    int d0;
    d0 = done_cnt;
    model(idb, ds);
    run_scan(idb, ds, restart_at);
    repeat (3) @(negedge clk_i);
    check_result(req);
    chk(done_cnt - d0 == 1, "R10", "done pulses", done_cnt - d0, 1);
  endtask

  initial begin
    int r0, d0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    chk(best_prio_o == 8'hFF, "R2", "reset prio", best_prio_o, 8'hFF);
    chk(best_id_o == 0, "R2", "reset id", best_id_o, 0);
    chk(best_grp_o == 0, "R8", "reset grp", best_grp_o, 0);
    chk(!done_o && !req_valid_o, "R10", "reset idle", {done_o, req_valid_o}, 0);

    // R7 tie to lower ID, R5 disabled entry skipped, R4 read count
    mem.delete();
    set_pend(8193, 8'h41); set_pend(8200, 8'h41);
    set_pend(9000, 8'h10); set_pend(12000, 8'h41); set_pend(8300, 8'hFF);
    mem[PB + 32'd10] = 8'hFF;
    r0 = reads;
    scan_and_check(13, 1, "R7", 0);
    chk(best_id_o == 14'd8193 && best_prio_o == 8'h40, "R7", "tie lowest id", best_id_o, 8193);
    chk(reads - r0 == 1024 + 5, "R4", "read count", reads - r0, 1029);

    // R6 secure remap
    scan_and_check(13, 0, "R6", 0);
    chk(best_prio_o == 8'hA0, "R6", "secure remap", best_prio_o, 8'hA0);

    // R3 empty range, R2 id kept
    r0 = reads;
    scan_and_check(12, 1, "R3", 0);
    chk(reads == r0, "R3", "no reads on empty range", reads - r0, 0);
    chk(best_id_o == 14'd8193 && best_prio_o == 8'hFF, "R2", "idle with kept id", best_id_o, 8193);

    // R3 width clipped, last ID of the table
    mem.delete();
    set_pend(16383, 8'h05);
    mem[PB + 32'd2048] = 8'hFF;
    scan_and_check(20, 1, "R3", 0);
    chk(best_id_o == 14'd16383 && best_prio_o == 8'h04, "R3", "clipped top id", best_id_o, 16383);

    // R5 only disabled pending entries
    mem.delete();
    set_pend(9000, 8'h20);
    scan_and_check(13, 1, "R5", 0);

    // R1 gating: enable low, then each base zero
    for (int g = 0; g < 3; g++) begin
      r0 = reads; d0 = done_cnt;
      @(negedge clk_i);
      scan_en_i = (g != 0); cfg_base_i = (g == 1) ? 32'h0 : CB; pend_base_i = (g == 2) ? 32'h0 : PB;
      start_i = 1;
      @(negedge clk_i);
      start_i = 0;
      repeat (40) @(negedge clk_i);
      chk(reads == r0 && done_cnt == d0, "R1", "gated start inert", reads - r0 + done_cnt - d0, 0);
      chk(best_prio_o == 8'(exp_prio) && best_id_o == 14'(exp_id), "R1", "result held", best_id_o, exp_id);
    end
    @(negedge clk_i);
    scan_en_i = 1; cfg_base_i = CB; pend_base_i = PB;

    // R10 start pulse during a scan
    mem.delete();
    set_pend(8500, 8'h31); set_pend(15000, 8'h11); set_pend(15001, 8'h11);
    scan_and_check(13, 1, "R10", 100);

    // random tables
    for (int t = 0; t < 6; t++) begin
      bit ds;
      int n, idb;
      mem.delete();
      n = 4 + int'($urandom % 24);
      for (int k = 0; k < n; k++)
        set_pend(8192 + int'($urandom % 8192), 8'({$urandom % 4, 4'h0, 2'($urandom % 4)}) | 8'(($urandom % 2) * 8'h40));
      for (int k = 0; k < 8; k++) mem[PB + 32'($urandom % 1024)] = 8'($urandom);
      ds = 1'($urandom % 2);
      idb = (t % 2 == 0) ? 13 : 14 + int'($urandom % 18);
      scan_and_check(idb, ds, (ds ? "R7" : "R6"), 0);
    end

    chk(proto_bad == 0, "R9", "handshake violations", proto_bad, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule